// File: doc/BRIEF.md
# Programmable four-tap FIR filter

This block is a direct-form FIR filter with four taps. Each accepted sample produces one output, y[n] = c0·x[n] + c1·x[n-1] + c2·x[n-2] + c3·x[n-3]. Samples and coefficients are signed two's complement values. The four coefficients can be reloaded at any time through an indexed write port, so one instance can serve several filter responses without stopping the sample stream.

Each coefficient is the multiplicand of its tap, and each delayed sample is the multiplier. Every sample is recoded into radix-8 signed digits in the range -4..+4. The digit ±3 needs three times the coefficient. That value is formed once, as (coefficient << 1) + coefficient, when the coefficient is written, and it is kept in a register beside the coefficient. The partial-product rows of all taps go together into one carry-save tree of 3:2 compressors. The tree leaves two rows, and only those two pass through a single carry-propagate adder. The result is then registered.

Top module: `fir4_prog`

## Requirements
- R1: When `in_valid` is high at a rising edge, `y_out` takes the value c0·x + c1·h0 + c2·h1 + c3·h2 after that edge, as a signed 19-bit number. Here x is `in_sample` and h0..h2 are the three previously accepted samples, newest first.
- R2: `out_valid` is high in exactly the cycles that follow an edge where `in_valid` was high, and low in all other cycles.
- R3: When `in_valid` is low at an edge, the sample history does not shift and `y_out` keeps its previous value.
- R4: When `coef_we` is high at an edge, coefficient index `coef_idx` takes `coef_data` at that edge. Index 0 multiplies the newest sample and index 3 multiplies the oldest. A sample accepted at the same edge still uses the old coefficient. Samples accepted at later edges use the new one.
- R5: The stored triple always equals three times its coefficient. Results are exact for sample values whose recoding contains the digits ±3.
- R6: Radix-8 recoding gives the exact product over the full signed 8-bit range of both operands, including -128.
- R7: The merged carry-save reduction gives the exact sum at full scale. All coefficients at -128 with four samples at -128 give 65536. All coefficients at 127 with four samples at -128 give -65024.
- R8: A synchronous reset clears the sample history, all coefficients, all triples, `y_out` and `out_valid`.
- R9: A coefficient write changes only the indexed coefficient. The other three keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; accepts `in_sample` and shifts the history |
| in_sample | input | 8 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | 2 | Tap index of the coefficient being written |
| coef_data | input | 8 | Signed coefficient value to write |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| y_out | output | 19 | Signed filter output, held between samples |

## Verification
The bench builds the block with its defaults: four taps, 8-bit samples and 8-bit coefficients. With these values every sample splits into three radix-8 digits, and the top digit is formed from a copy of the sign bit. The tree then receives twelve rows and needs five compressor levels before the final adder. At this width the bench can sweep all 256 sample values against random coefficients. It can also reach the full-scale corner, where the sum needs 18 of the 19 output bits. Random coefficient reloads that land on the same edge as a sample exercise the ordering rule between writes and accepted samples.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  // Value of one radix-8 signed digit from a 4-bit window {b(3i+2), b(3i+1), b(3i), b(3i-1)}
  function automatic logic signed [3:0] booth_digit(input logic [3:0] q);
    int v;
    v = (q[2] ? 2 : 0) + int'(q[1]) + int'(q[0]) - (q[3] ? 4 : 0);
    return 4'(v);
  endfunction

  // Rows left after one level of 3:2 compression
  function automatic int next_rows(input int n);
    return (n / 3) * 2 + (n % 3);
  endfunction

  function automatic int rows_at(input int n, input int level);
    int r;
    r = n;
    for (int i = 0; i < level; i++) r = next_rows(r);
    return r;
  endfunction

  function automatic int tree_depth(input int n);
    int r;
    int d;
    r = n;
    d = 0;
    while (r > 2) begin
      r = next_rows(r);
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/fir4_coef_bank.sv
module fir4_coef_bank #(
  parameter int TAPS   = 4,
  parameter int COEF_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [IDX_W-1:0]                   idx,
  input  logic [COEF_W-1:0]                  wdata,
  output logic [TAPS-1:0][COEF_W-1:0]        coef,
  output logic [TAPS-1:0][COEF_W+1:0]        triple
);

  function automatic logic [COEF_W+1:0] triple_of(input logic [COEF_W-1:0] w);
    return {{2{w[COEF_W-1]}}, w} + {w[COEF_W-1], w, 1'b0};
  endfunction

  logic [COEF_W+1:0] wtriple;
  assign wtriple = triple_of(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      coef   <= '0;
      triple <= '0;
    end else if (we) begin
      coef[idx]   <= wdata;
      triple[idx] <= wtriple;
    end
  end

  // R4: a write lands in the indexed register at the next edge
  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> coef[$past(idx)] == $past(wdata));

  for (genvar k = 0; k < TAPS; k++) begin : g_chk
    // R5: triple register tracks its coefficient
    a_r5_triple_tracks: assert property (@(posedge clk) disable iff (rst)
      int'($signed(triple[k])) == 3 * int'($signed(coef[k])));
    // R9: taps that are not addressed keep their value
    a_r9_others_keep: assert property (@(posedge clk) disable iff (rst)
      !(we && idx == IDX_W'(k)) |=> $stable(coef[k]));
  end

  // R8: reset clears the bank
  a_r8_bank_cleared: assert property (@(posedge clk)
    rst |=> (coef == '0) && (triple == '0));

endmodule

// File: rtl/fir4_delay_line.sv
module fir4_delay_line #(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        shift,
  input  logic [DATA_W-1:0]           din,
  output logic [TAPS-1:0][DATA_W-1:0] window
);

  logic [TAPS-2:0][DATA_W-1:0] hist;

  assign window[0] = din;
  for (genvar k = 1; k < TAPS; k++) begin : g_win
    assign window[k] = hist[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (shift) begin
      hist[0] <= din;
      for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
    end
  end

  // R3: history advances only on an accepted sample
  a_r3_shift_on_valid: assert property (@(posedge clk) disable iff (rst)
    shift |=> hist[0] == $past(din));
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(hist));

endmodule

// File: rtl/fir4_booth_rows.sv
module fir4_booth_rows
  import fir4_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int OUT_W  = 19,
  parameter int NDIG   = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [TAPS-1:0][DATA_W-1:0]       window,
  input  logic [TAPS-1:0][COEF_W-1:0]       coef,
  input  logic [TAPS-1:0][COEF_W+1:0]       triple,
  output logic [TAPS*NDIG-1:0][OUT_W-1:0]   rows
);

  localparam int PAD_W = 3 * NDIG + 1;
  localparam int EXT_W = 3 * NDIG - DATA_W;

  // One partial-product row: digit times multiplicand, weighted by 8^i
  function automatic logic [OUT_W-1:0] pp_row(input logic [3:0] q,
                                               input logic [COEF_W-1:0] c,
                                               input logic [COEF_W+1:0] t,
                                               input int pos);
    logic signed [3:0] d;
    logic [OUT_W-1:0] m;
    int mag;
    d   = booth_digit(q);
    mag = (d < 0) ? -int'(d) : int'(d);
    case (mag)
      1:       m = OUT_W'($signed(c));
      2:       m = OUT_W'($signed(c)) << 1;
      3:       m = OUT_W'($signed(t));
      4:       m = OUT_W'($signed(c)) << 2;
      default: m = '0;
    endcase
    if (d < 0) m = ~m + 1'b1;
    return m << pos;
  endfunction

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    wire [PAD_W-1:0] pad;
    assign pad = {{EXT_W{window[t][DATA_W-1]}}, window[t], 1'b0};

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      assign rows[t*NDIG+i] = pp_row(pad[3*i+3:3*i], coef[t], triple[t], 3 * i);
    end

    logic [OUT_W-1:0] tap_total;
    logic [OUT_W-1:0] tap_ref;
    always_comb begin
      tap_total = '0;
      for (int i = 0; i < NDIG; i++) tap_total += rows[t*NDIG+i];
    end
    assign tap_ref = OUT_W'($signed(coef[t])) * OUT_W'($signed(window[t]));

    // R6: the rows of one tap add up to the exact product
    a_r6_booth_exact: assert property (@(posedge clk) disable iff (rst)
      tap_total == tap_ref);
  end

endmodule

// File: rtl/fir4_csa_tree.sv
module fir4_csa_tree
  import fir4_pkg::*;
#(
  parameter int N = 12,
  parameter int W = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0][W-1:0]  rows,
  output logic [W-1:0]         sum_row,
  output logic [W-1:0]         carry_row
);

  localparam int LEVELS = tree_depth(N);
  localparam int LAST   = rows_at(N, LEVELS);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CUR = rows_at(N, l);
    wire [CUR-1:0][W-1:0] r;
    if (l == 0) begin : g_in
      assign r = rows;
    end else begin : g_cmp
      localparam int PREV = rows_at(N, l - 1);
      localparam int GRP  = PREV / 3;
      localparam int REM  = PREV % 3;
      for (genvar g = 0; g < GRP; g++) begin : g_fa
        wire [W-1:0] a;
        wire [W-1:0] b;
        wire [W-1:0] c;
        assign a = g_lvl[l-1].r[3*g];
        assign b = g_lvl[l-1].r[3*g+1];
        assign c = g_lvl[l-1].r[3*g+2];
        assign r[2*g]   = a ^ b ^ c;
        assign r[2*g+1] = ((a & b) | (a & c) | (b & c)) << 1;
      end
      for (genvar p = 0; p < REM; p++) begin : g_pass
        assign r[2*GRP+p] = g_lvl[l-1].r[3*GRP+p];
      end
    end
  end

  assign sum_row = g_lvl[LEVELS].r[0];
  if (LAST >= 2) begin : g_two
    assign carry_row = g_lvl[LEVELS].r[1];
  end else begin : g_one
    assign carry_row = '0;
  end

  logic [W-1:0] row_total;
  always_comb begin
    row_total = '0;
    for (int i = 0; i < N; i++) row_total += rows[i];
  end

  // R7: compression keeps the arithmetic sum of all rows
  a_r7_tree_conserves: assert property (@(posedge clk) disable iff (rst)
    row_total == W'(sum_row + carry_row));

endmodule

// File: rtl/fir4_prog.sv
module fir4_prog #(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  localparam int IDX_W  = $clog2(TAPS),
  localparam int OUT_W  = DATA_W + COEF_W + $clog2(TAPS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic              coef_we,
  input  logic [IDX_W-1:0]  coef_idx,
  input  logic [COEF_W-1:0] coef_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  y_out
);

  localparam int NDIG = (DATA_W + 3) / 3;
  localparam int ROWS = TAPS * NDIG;

  logic                          sample_take;
  logic                          coef_take;
  logic [TAPS-1:0][DATA_W-1:0]   window;
  logic [TAPS-1:0][COEF_W-1:0]   coef;
  logic [TAPS-1:0][COEF_W+1:0]   triple;
  logic [ROWS-1:0][OUT_W-1:0]    rows;
  logic [OUT_W-1:0]              red_sum;
  logic [OUT_W-1:0]              red_carry;
  logic [OUT_W-1:0]              acc_next;

  assign sample_take = in_valid;
  assign coef_take   = coef_we;

  fir4_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .we(coef_take), .idx(coef_idx), .wdata(coef_data),
    .coef(coef), .triple(triple)
  );

  fir4_delay_line #(.TAPS(TAPS), .DATA_W(DATA_W)) u_line (
    .clk(clk), .rst(rst), .shift(sample_take), .din(in_sample), .window(window)
  );

  fir4_booth_rows #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W),
                    .OUT_W(OUT_W), .NDIG(NDIG)) u_rows (
    .clk(clk), .rst(rst), .window(window), .coef(coef), .triple(triple), .rows(rows)
  );

  fir4_csa_tree #(.N(ROWS), .W(OUT_W)) u_tree (
    .clk(clk), .rst(rst), .rows(rows), .sum_row(red_sum), .carry_row(red_carry)
  );

  assign acc_next = red_sum + red_carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_out     <= '0;
    end else begin
      out_valid <= sample_take;
      if (sample_take) y_out <= acc_next;
    end
  end

  // R2: output strobe is the input strobe one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    sample_take |=> out_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !sample_take |=> !out_valid);
  // R3: output holds between samples
  a_r3_output_holds: assert property (@(posedge clk) disable iff (rst)
    !sample_take |=> $stable(y_out));
  // R8: reset clears the output side
  a_r8_output_cleared: assert property (@(posedge clk)
    rst |=> (y_out == '0) && !out_valid);

endmodule

// File: tb/tb_fir4_prog.sv
module tb_fir4_prog;
  localparam int TAPS   = 4;
  localparam int DATA_W = 8;
  localparam int COEF_W = 8;
  localparam int IDX_W  = 2;
  localparam int OUT_W  = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_sample = '0;
  logic coef_we = 1'b0;
  logic [IDX_W-1:0] coef_idx = '0;
  logic [COEF_W-1:0] coef_data = '0;
  logic out_valid;
  logic [OUT_W-1:0] y_out;

  always #4 clk = ~clk;

  fir4_prog dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
    .out_valid(out_valid), .y_out(y_out)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  string tag = "R1";
  int coefm[TAPS];
  int histm[TAPS-1];
  logic [OUT_W-1:0] last_y = '0;
  bit done = 0;

  function automatic int rnd_val();
    if ($urandom_range(7) == 0) return -128;
    return int'($urandom_range(255)) - 128;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: applies one cycle of stimulus, pushes the expected result
  task automatic step(bit v, int x, bit we, int idx, int c);
    int e;
    @(posedge clk); #1;
    in_valid  = v;
    in_sample = DATA_W'(x);
    coef_we   = we;
    coef_idx  = IDX_W'(idx);
    coef_data = COEF_W'(c);
    if (v) begin
      e = coefm[0] * x;
      for (int k = 1; k < TAPS; k++) e += coefm[k] * histm[k-1];
      exp_q.push_back(e);
      tag_q.push_back(tag);
      for (int k = TAPS - 2; k > 0; k--) histm[k] = histm[k-1];
      histm[0] = x;
    end
    if (we) coefm[idx] = c;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    exp_q.delete(); tag_q.delete();
    foreach (coefm[k]) coefm[k] = 0;
    foreach (histm[k]) histm[k] = 0;
    @(negedge clk);
    check("R8 y_out after reset", int'($signed(y_out)), 0);
    check("R8 out_valid after reset", int'(out_valid), 0);
  endtask

  // Monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected out_valid", 1, 0);
        end else begin
          string t;
          int e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, int'($signed(y_out)), e);
        end
      end else begin
        check("R3 hold while idle", int'($signed(y_out)), int'($signed(last_y)));
      end
    end
    last_y = y_out;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R8: cleared coefficients give zero output
    tag = "R8";
    for (int i = 0; i < 4; i++) step(1, rnd_val(), 0, 0, 0);

    // R9 and R4: single tap written, impulse response shows only that tap
    tag = "R9";
    step(0, 0, 1, 2, 5);
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
    tag = "R4";
    step(1, 10, 1, 0, 7);   // same-edge write: old coefficient applies
    step(1, 10, 0, 0, 0);   // new coefficient applies
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // R5: samples whose recoding holds +/-3 digits
    tag = "R5";
    step(0, 0, 1, 0, -128); step(0, 0, 1, 1, 127);
    step(0, 0, 1, 2, -3);   step(0, 0, 1, 3, 85);
    foreach (histm[k]) begin end
    step(1, 3, 0, 0, 0);  step(1, -3, 0, 0, 0);
    step(1, 27, 0, 0, 0); step(1, -101, 0, 0, 0);
    step(1, 59, 0, 0, 0); step(1, -37, 0, 0, 0);

    // R6: every sample value against random coefficients
    tag = "R6";
    for (int k = 0; k < TAPS; k++) step(0, 0, 1, k, rnd_val());
    for (int x = -128; x < 128; x++) step(1, x, 0, 0, 0);

    // R7: full-scale sums
    tag = "R7";
    for (int k = 0; k < TAPS; k++) step(0, 0, 1, k, -128);
    for (int i = 0; i < 4; i++) step(1, -128, 0, 0, 0);
    for (int k = 0; k < TAPS; k++) step(0, 0, 1, k, 127);
    for (int i = 0; i < 4; i++) step(1, -128, 0, 0, 0);

    // R1, R2, R3: random traffic with reloads
    tag = "R1";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(3) != 0, rnd_val(), $urandom_range(7) == 0,
           int'($urandom_range(TAPS - 1)), rnd_val());

    // R8: reset in mid-run clears history and coefficients
    do_reset();
    tag = "R8";
    step(1, 77, 1, 0, 9);
    step(1, 4, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    check("R2 all outputs delivered", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule